// File: doc/BRIEF.md
# Byte-Wide SPI Master with Two-Step Completion Flag

This block is a byte-oriented SPI master that sits behind a small register port. A write to the data register starts an 8-bit full-duplex exchange. The block drives the serial clock and the outgoing data line, and it captures the incoming line. When all eight bits have been exchanged, a completion flag is raised in the status register. The received byte can then be read from the data register. To clock in a byte from a slave, software writes any filler byte, because that write is the only way to produce the eight clocks.

The completion flag does not clear on a single access. Software first reads the status register while the flag is set. That read arms the clear. The next read of the data register then drops the flag. A write to the data register while a transfer is running does not start anything and does not change the byte being shifted. It only sets a collision bit, which clears through the same two-step sequence. An interrupt request follows the completion flag whenever the enable bit is set. Chip select is not part of this block and is left to a general-purpose output.

Top module: `spi_flag_master`

## Requirements
- R1: A synchronous active-high reset clears the shift state, the received byte, both flags and the interrupt enable. After reset, every register reads 0x00, the serial clock is low and the interrupt request is low.
- R2: A write to the data register (address 0) while idle starts a transfer on the next cycle. The transfer makes exactly 8 serial-clock pulses, each high for CLK_DIV/2 cycles and low for CLK_DIV/2 cycles, and the serial clock idles low. The status register has a busy bit at bit 0, which reads 1 during the transfer.
- R3: The link works in mode 0 with the most significant bit first. The first bit is on the outgoing line before the first rising clock edge. The outgoing line changes only while the clock is low. The incoming line is sampled on each rising edge.
- R4: The completion flag is bit 7 of the status register (address 1). It reads 1 exactly 16*(CLK_DIV/2) cycles after the clock edge that accepted the data write, and busy clears at the same moment.
- R5: After completion, a read of the data register returns the 8 bits received on the incoming line during that transfer, with the first-received bit as bit 7.
- R6: A status read made while the flag is set, followed by a data-register read, clears the flag. A data-register read with no prior armed status read leaves the flag set.
- R7: A data-register write during a transfer has no effect on the transfer: the transmitted and received bytes are unchanged. It sets the collision bit, which is bit 6 of the status register. The collision bit clears through the same two-step sequence as the completion flag.
- R8: The interrupt request equals the completion flag when the enable bit is set. The enable bit is bit 0 of the control register (address 2). When the enable bit is clear, the interrupt request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 2 | Register select: 0 data, 1 status, 2 control |
| busWrite | input | 1 | Write strobe for one cycle |
| busRead | input | 1 | Read strobe for one cycle; it carries the clear side effects |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected register (combinational) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the ones that depend on the order of register accesses around the flag. These are a collision write landing in the middle of a running transfer, and a data read that comes without the arming status read. The bench handles the first case by counting serial-clock edges and issuing the stray write once a few bits have gone out. It then confirms through the serial monitor that the original byte kept shifting. For the second case, the bench peeks at the status value without using the read strobe, so that checking the flag does not itself arm the clear.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int BIT_DONE = 7;
  localparam int BIT_WCOL = 6;
  localparam int BIT_BUSY = 0;

  typedef struct packed {
    logic load;     // take a new byte into the shifter
    logic rise;     // serial clock goes high, sample input
    logic fall;     // serial clock goes low, advance shifter
    logic capture;  // last fall: keep received byte
  } spiStrobe_t;
endpackage

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] busAddr,
  input  logic       busWrite,
  input  logic       busRead,
  input  logic       busWdata0,
  output spiStrobe_t strobe,
  output logic       busy,
  output logic       flagDone,
  output logic       flagWcol,
  output logic       irqEn
);
  localparam int HALF    = CLK_DIV / 2;
  localparam int DIV_W   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CNT_W   = $clog2(DATA_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             highPhase;
  logic             armed;
  logic             tick;
  logic             dataWr, dataRd, statRd, ctrlWr;

  assign dataWr = busWrite && (busAddr == ADDR_DATA);
  assign dataRd = busRead  && (busAddr == ADDR_DATA);
  assign statRd = busRead  && (busAddr == ADDR_STATUS);
  assign ctrlWr = busWrite && (busAddr == ADDR_CTRL);
  assign tick   = (state == ST_RUN) && (divCnt == DIV_LAST);
  assign busy   = (state == ST_RUN);

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_IDLE) && dataWr;
    strobe.rise    = tick && !highPhase;
    strobe.fall    = tick && highPhase;
    strobe.capture = tick && highPhase && (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      highPhase <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (dataWr) begin
        state     <= ST_RUN;
        divCnt    <= '0;
        bitCnt    <= '0;
        highPhase <= 1'b0;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        highPhase <= !highPhase;
        if (highPhase) begin
          if (bitCnt == BIT_LAST) state <= ST_IDLE;
          else bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagDone <= 1'b0;
      flagWcol <= 1'b0;
      armed    <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (ctrlWr) irqEn <= busWdata0;
      if (statRd && (flagDone || flagWcol)) armed <= 1'b1;
      if (dataRd && armed) begin
        flagDone <= 1'b0;
        flagWcol <= 1'b0;
        armed    <= 1'b0;
      end
      if (strobe.capture) flagDone <= 1'b1;
      if (busy && dataWr) flagWcol <= 1'b1;
    end
  end

  p_flag_source_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flagDone) |-> $past(state == ST_RUN));

  p_wcol_on_busy_write_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && dataWr) |=> flagWcol);

  p_clear_needs_arm_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flagDone) |-> $past(dataRd && armed));
endmodule

// File: rtl/spi_flag_datapath.sv
module spi_flag_datapath
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spiStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shiftReg;
  logic              sampleBit;
  logic [DATA_W-1:0] nextShift;

  assign nextShift = {shiftReg[DATA_W-2:0], sampleBit};
  assign mosi      = shiftReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      sck       <= 1'b0;
      rxData    <= '0;
    end else begin
      if (strobe.load) shiftReg <= loadData;
      if (strobe.rise) begin
        sck       <= 1'b1;
        sampleBit <= miso;
      end
      if (strobe.fall) begin
        sck      <= 1'b0;
        shiftReg <= nextShift;
        if (strobe.capture) rxData <= nextShift;
      end
    end
  end

  p_mosi_steady_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/spi_flag_master.sv
module spi_flag_master
  import spi_flag_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  spiStrobe_t        strobe;
  logic              busy, flagDone, flagWcol, irqEn;
  logic [DATA_W-1:0] rxData;
  logic [DATA_W-1:0] statusWord;

  spi_flag_ctrl #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata0(busWdata[0]), .strobe(strobe),
    .busy(busy), .flagDone(flagDone), .flagWcol(flagWcol), .irqEn(irqEn)
  );

  spi_flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .loadData(busWdata),
    .miso(miso), .sck(sck), .mosi(mosi), .rxData(rxData)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_DONE] = flagDone;
    statusWord[BIT_WCOL] = flagWcol;
    statusWord[BIT_BUSY] = busy;
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA:   busRdata = rxData;
      ADDR_STATUS: busRdata = statusWord;
      ADDR_CTRL:   busRdata = {{(DATA_W-1){1'b0}}, irqEn};
      default:     busRdata = '0;
    endcase
  end

  assign irq = flagDone && irqEn;

  p_sck_low_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
endmodule

// File: tb/spi_flag_master_tb.sv
module spi_flag_master_tb;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] busAddr = 2'd3;
  logic       busWrite = 1'b0;
  logic       busRead = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] txQ[$];
  logic [7:0] slaveShift = '0;
  logic [7:0] monByte = '0;
  int         monBits = 0;
  int         riseCount = 0;
  int         highLen = 0;

  always #4 clk = ~clk;

  spi_flag_master #(.CLK_DIV(CLK_DIV), .DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // slave model: mode 0, next bit after each falling clock edge
  always @(negedge sck) begin
    slaveShift = {slaveShift[6:0], 1'b0};
    miso = slaveShift[7];
  end

  // monitor: collect outgoing bits on rising edges, compare against queue
  always @(posedge sck) begin
    monByte = {monByte[6:0], mosi};
    monBits++;
    riseCount++;
    if (monBits == 8) begin
      monBits = 0;
      if (txQ.size() == 0) check("R3 unexpected byte", monByte, 8'hxx);
      else check("R3 mosi byte", monByte, txQ.pop_front());
    end
  end

  // high-time measurement of each serial clock pulse
  always @(posedge clk) begin
    if (sck) highLen++;
    else if (highLen != 0) begin
      check("R2 sck high length", 8'(highLen), 8'(HALF));
      highLen = 0;
    end
  end

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 2'd3;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0; busAddr = 2'd3;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
    busAddr = 2'd3;
  endtask

  // driver: queue expected outgoing byte, preload slave, start transfer
  task automatic startXfer(input logic [7:0] tx, input logic [7:0] sl);
    txQ.push_back(tx);
    slaveShift = sl;
    miso = sl[7];
    busWr(2'd0, tx);
  endtask

  task automatic waitDone();
    logic [7:0] s;
    s = 8'h00;
    while (s[7] !== 1'b1) begin
      @(negedge clk);
      peek(2'd1, s);
    end
  endtask

  task automatic fullXfer(input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] s, d;
    int r0;
    r0 = riseCount;
    startXfer(tx, sl);
    waitDone();
    @(negedge clk);
    check("R2 eight clock pulses", 8'(riseCount - r0), 8'd8);
    busRd(2'd1, s);
    check("R4 status done only", s, 8'h80);
    busRd(2'd0, d);
    check("R5 received byte", d, sl);
    peek(2'd1, s);
    check("R6 cleared after sequence", s, 8'h00);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    peek(2'd1, v); check("R1 status reset", v, 8'h00);
    peek(2'd0, v); check("R1 data reset", v, 8'h00);
    peek(2'd2, v); check("R1 ctrl reset", v, 8'h00);
    check("R1 sck low", {7'b0, sck}, 8'h00);
    check("R1 irq low", {7'b0, irq}, 8'h00);

    // R3: first bit present before first rising edge
    txQ.push_back(8'hC3);
    slaveShift = 8'h5A; miso = 1'b0;
    @(negedge clk);
    busAddr = 2'd0; busWdata = 8'hC3; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 2'd3;
    check("R3 msb before first edge", {7'b0, mosi}, 8'h01);
    check("R3 sck still low", {7'b0, sck}, 8'h00);
    peek(2'd1, v); check("R2 busy bit", v, 8'h01);
    // written at edge E0; now at E0+0.5. flag expected at E0+16*HALF
    repeat (16*HALF - 1) @(posedge clk);
    #1 peek(2'd1, v); check("R4 not yet done", v[7:0] & 8'h80, 8'h00);
    @(posedge clk);
    #1 peek(2'd1, v); check("R4 done on time", v, 8'h80);
    busRd(2'd1, v);
    busRd(2'd0, v); check("R5 received 5A", v, 8'h5A);

    // several patterns (R5, R3)
    fullXfer(8'hA5, 8'h3C);
    fullXfer(8'h00, 8'hFF);
    fullXfer(8'hFF, 8'h00);
    fullXfer(8'h81, 8'h7E);

    // R6: data read without arming leaves flag set
    startXfer(8'h12, 8'h96);
    waitDone();
    busRd(2'd0, v); check("R6 data readable", v, 8'h96);
    peek(2'd1, v); check("R6 flag kept without status read", v, 8'h80);
    busRd(2'd1, v);
    busRd(2'd0, v);
    peek(2'd1, v); check("R6 flag cleared after pair", v, 8'h00);

    // R7: collision write mid transfer
    begin
      int r0;
      r0 = riseCount;
      startXfer(8'hA5, 8'h69);
      while (riseCount - r0 < 3) @(negedge clk);
      busWr(2'd0, 8'hFF);
      peek(2'd1, v); check("R7 collision bit while busy", v, 8'h41);
      waitDone();
      @(negedge clk);
      check("R7 pulses unchanged", 8'(riseCount - r0), 8'd8);
      peek(2'd1, v); check("R7 done and collision", v, 8'hC0);
      busRd(2'd1, v);
      busRd(2'd0, v); check("R7 received unchanged", v, 8'h69);
      peek(2'd1, v); check("R7 collision cleared", v, 8'h00);
    end

    // R8: interrupt enable
    startXfer(8'h3E, 8'h11);
    waitDone();
    @(negedge clk);
    check("R8 irq low when disabled", {7'b0, irq}, 8'h00);
    busWr(2'd2, 8'h01);
    check("R8 irq follows flag", {7'b0, irq}, 8'h01);
    busRd(2'd1, v);
    busRd(2'd0, v);
    check("R8 irq drops with flag", {7'b0, irq}, 8'h00);
    peek(2'd2, v); check("R8 enable readback", v, 8'h01);

    repeat (4) @(negedge clk);
    check("R3 monitor queue drained", 8'(txQ.size()), 8'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule